// File: doc/BRIEF.md
# SPI Slave Frame-Error Checker

This block sits at the receive side of an SPI slave that serves a small register map. It watches chip select, serial clock and serial data and counts the clock pulses in each frame. It checks every address byte it takes in. Each frame is judged when chip select returns high. A rule violation sets a sticky error bit in an 8-bit global status word. Because that word is loaded into the response shifter at the start of a frame, an error shows up one frame late. The response also carries a global error flag that is the OR of all failure indications.

The pins are oversampled with a system clock. The caller must deliver SCLK and CSN already synchronised to it. Each address byte is laid out as follows:

- Bits 7:2 are the register address, exported as `reg_addr`.
- Bit 1 is the last-address token.
- Bit 0 is a marker bit that must be 1.

The register map answers on `addr_used`. Address 0 selects the global status word. A correct frame that addresses it reads the word and clears it. The `daisy_mode` input selects between a single slave on its own chip select and a slave placed in a shift chain.

Top module: `spi_frame_checker`

## Requirements
- R1: A frame is correct in length only if the number of SCLK rising edges while CSN is low is 0, or is a multiple of 8 and at least 16. Any other count is an error.
- R2: Bit 0 of every address byte must be 1. A 0 there is an error, so an all-zero frame is flagged.
- R3: The address field (bits 7:2) of the byte that addresses this device must be decoded as used by `addr_used`, or must equal the status address 0. Otherwise it is an error, so an all-ones frame (address 63) is flagged. `reg_addr` holds its value while CSN is high.
- R4: With `daisy_mode`=0, the first byte of the frame is the address byte and its bit 1 must be 1.
- R5: With `daisy_mode`=1, leading bytes with bit 1 = 0 are passed over and have only their bit 0 checked. The first byte with bit 1 = 1 is this device's address and gets the R3 check. A frame that has at least one byte but no such byte is an error.
- R6: SCLK high at the falling or the rising edge of CSN is an error.
- R7: The error bit is `status[7]`. It is updated only when CSN rises, so the response of the erroneous frame itself still shows the old value.
- R8: `status[7]` stays set until a frame with no error addresses address 0. At the end of that frame it clears. An erroneous frame never clears it.
- R9: The power-on indication `status[3]` is 0 after reset. It becomes 1 at the end of the first correct address-0 frame and then stays 1.
- R10: The global status word is {err, fault_in[4], fault_in[3], fault_in[2], power-on bit, fault_in[1], fault_in[0], 0}. `gef` is 1 when the error bit, any `fault_in` bit, or a 0 power-on bit is present.
- R11: SDO outputs `gef` first, then the status word MSB first, then zeros. The word is captured at the CSN falling edge and advances on each SCLK falling edge. SDO is 0 while CSN is high.
- R12: A frame with no SCLK pulses, and with SCLK low at both CSN edges, changes neither status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| csn | input | 1 | Chip select, active low, synchronised to clk |
| sclk | input | 1 | Serial clock, idle low, synchronised to clk |
| sdi | input | 1 | Serial data in, sampled on SCLK rising edges |
| daisy_mode | input | 1 | 1 selects chained addressing, 0 selects a single slave |
| fault_in | input | 5 | Failure indications merged into the status word |
| reg_addr | output | 6 | Address field of the last captured address byte |
| addr_used | input | 1 | Register map decode of `reg_addr`, valid one clock after it changes |
| sdo | output | 1 | Serial response data |
| gef | output | 1 | Global error flag |
| status | output | 8 | Global status word |

## Verification
The assertions assume these things about the inputs:
- CSN is held high through reset.
- SCLK and CSN change only on clk edges and only after synchronisation.
- The address check one clock after a byte completes happens before CSN can rise.

Under those assumptions, the error and power-on bits can change only in the clock after a CSN rising edge, and `reg_addr` stays still while CSN is high. The bench drives every pin on falling clk edges and holds each SCLK level for several clocks. It leaves a gap of at least four clocks around each CSN edge, so every pin change is seen as a clean edge and the deferred address check is finished before the frame closes.

// File: rtl/spi_frame_checker.sv
module spi_frame_checker #(
  parameter int ADDR_W = 6,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csn,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              daisy_mode,
  input  logic [4:0]        fault_in,
  output logic [ADDR_W-1:0] reg_addr,
  input  logic              addr_used,
  output logic              sdo,
  output logic              gef,
  output logic [7:0]        status
);
  localparam int BYTE_W = ADDR_W + 2;
  localparam int IDX_W  = $clog2(BYTE_W);
  localparam int TX_W   = 9;

  logic              csn_q, sclk_q;
  logic [BYTE_W-2:0] rx_sh;
  logic [IDX_W-1:0]  bit_idx;
  logic [1:0]        nbytes;
  logic [BYTE_W-1:0] addr_q;
  logic              chk, addr_phase, status_hit, frame_bad;
  logic              spi_err, npor;
  logic [TX_W-1:0]   tx_sh;

  wire csn_fall  = csn_q & ~csn;
  wire csn_rise  = ~csn_q & csn;
  wire sclk_rise = ~csn & ~sclk_q & sclk;
  wire sclk_fall = ~csn & sclk_q & ~sclk;
  wire byte_end  = sclk_rise && (bit_idx == IDX_W'(BYTE_W - 1));

  wire is_status = (addr_q[BYTE_W-1:2] == STATUS_ADDR);
  wire hit_used  = addr_used | is_status;
  wire own_byte  = ~daisy_mode | addr_q[1];
  wire chk_bad   = ~addr_q[0] | (own_byte & ~hit_used) | (~daisy_mode & ~addr_q[1]);

  wire count_ok    = (bit_idx == '0) && (nbytes != 2'd1);
  wire tok_missing = daisy_mode & addr_phase & (nbytes != 2'd0);
  wire end_bad     = frame_bad | sclk | ~count_ok | tok_missing;

  assign status   = {spi_err, fault_in[4:2], npor, fault_in[1:0], 1'b0};
  assign gef      = spi_err | ~npor | (|fault_in);
  assign reg_addr = addr_q[BYTE_W-1:2];
  assign sdo      = ~csn & tx_sh[TX_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csn_q      <= 1'b1;
      sclk_q     <= 1'b0;
      rx_sh      <= '0;
      bit_idx    <= '0;
      nbytes     <= '0;
      addr_q     <= '0;
      chk        <= 1'b0;
      addr_phase <= 1'b0;
      status_hit <= 1'b0;
      frame_bad  <= 1'b0;
      spi_err    <= 1'b0;
      npor       <= 1'b0;
      tx_sh      <= '0;
    end else begin
      csn_q  <= csn;
      sclk_q <= sclk;
      chk    <= byte_end & addr_phase;
      if (csn_fall) begin
        bit_idx    <= '0;
        nbytes     <= '0;
        addr_phase <= 1'b1;
        status_hit <= 1'b0;
        frame_bad  <= sclk;
        tx_sh      <= {gef, status};
      end else begin
        if (sclk_rise) begin
          rx_sh   <= {rx_sh[BYTE_W-3:0], sdi};
          bit_idx <= byte_end ? '0 : bit_idx + IDX_W'(1);
        end
        if (byte_end) begin
          if (nbytes != 2'd2) nbytes <= nbytes + 2'd1;
          if (addr_phase) addr_q <= {rx_sh, sdi};
        end
        if (chk && addr_phase) begin
          frame_bad <= frame_bad | chk_bad;
          if (own_byte) begin
            addr_phase <= 1'b0;
            status_hit <= is_status;
          end
        end
        if (sclk_fall) tx_sh <= {tx_sh[TX_W-2:0], 1'b0};
      end
      if (csn_rise) begin
        if (end_bad) spi_err <= 1'b1;
        else if (status_hit) begin
          spi_err <= 1'b0;
          npor    <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_frame_checker_sva.sv
module spi_frame_checker_sva #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              csn,
  input logic [7:0]        status,
  input logic [ADDR_W-1:0] reg_addr
);
  assert_err_set_at_frame_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[7]) |-> ($past(csn) && !$past(csn, 2)));

  assert_err_clear_at_frame_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[7]) |-> ($past(csn) && !$past(csn, 2) && status[3]));

  assert_npor_set_at_frame_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[3]) |-> ($past(csn) && !$past(csn, 2)));

  assert_npor_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(status[3]) |-> status[3]);

  assert_addr_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (csn && $past(csn)) |-> $stable(reg_addr));
endmodule

bind spi_frame_checker spi_frame_checker_sva #(.ADDR_W(ADDR_W)) u_sva (
  .clk      (clk),
  .rst_n    (rst_n),
  .csn      (csn),
  .status   (status),
  .reg_addr (reg_addr)
);

// File: tb/spi_frame_checker_tb.sv
module spi_frame_checker_tb;
  logic       clk = 1'b0, rst_n = 1'b0, csn = 1'b1, sclk = 1'b0, sdi = 1'b0, daisy = 1'b0;
  logic [4:0] fault = '0;
  logic [5:0] reg_addr;
  logic       addr_used, sdo, gef;
  logic [7:0] status;
  logic [15:0] rx;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;
  assign addr_used = (reg_addr < 6'd32);

  spi_frame_checker u_dut (
    .clk(clk), .rst_n(rst_n), .csn(csn), .sclk(sclk), .sdi(sdi),
    .daisy_mode(daisy), .fault_in(fault), .reg_addr(reg_addr),
    .addr_used(addr_used), .sdo(sdo), .gef(gef), .status(status)
  );

  // {daisy, nbits, data right-justified, error expected}
  localparam logic [72:0] VEC [15] = '{
    {1'b0, 7'd16, 64'h17AA,         1'b0},  // R1 R3 correct frame
    {1'b0, 7'd8,  64'h17,           1'b1},  // R1 single byte
    {1'b0, 7'd24, 64'h17AA55,       1'b0},  // R1 three bytes
    {1'b0, 7'd12, 64'h17A,          1'b1},  // R1 not a byte multiple
    {1'b0, 7'd16, 64'h16AA,         1'b1},  // R2 marker bit 0
    {1'b0, 7'd16, 64'h15AA,         1'b1},  // R4 token 0
    {1'b0, 7'd16, 64'h97AA,         1'b1},  // R3 unused address 0x25
    {1'b0, 7'd16, 64'hFFFF,         1'b1},  // R3 stuck high
    {1'b0, 7'd16, 64'h0000,         1'b1},  // R2 stuck low
    {1'b1, 7'd16, 64'h17AA,         1'b0},  // R5 token on first byte
    {1'b1, 7'd24, 64'h1517AA,       1'b0},  // R5 one pass-through byte
    {1'b1, 7'd24, 64'h151555,       1'b1},  // R5 no token byte
    {1'b1, 7'd24, 64'h1417AA,       1'b1},  // R5 R2 pass-through marker 0
    {1'b1, 7'd24, 64'h15BF00,       1'b1},  // R5 R3 own address unused
    {1'b0, 7'd40, 64'h17_01020304,  1'b0}   // R1 five bytes
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input int nbits, input logic [63:0] data, input bit hi_fall,
                       input bit hi_rise, output logic [15:0] r);
    r = '0;
    @(negedge clk); sclk = hi_fall; idle(2);
    csn = 1'b0; idle(4);
    if (hi_fall) begin sclk = 1'b0; idle(4); end
    for (int i = 0; i < nbits; i++) begin
      sdi = data[nbits-1-i]; idle(2);
      if (i < 16) r[15-i] = sdo;
      sclk = 1'b1; idle(4);
      sclk = 1'b0; idle(2);
    end
    if (hi_rise) begin sclk = 1'b1; idle(4); end
    csn = 1'b1; idle(4);
    sclk = 1'b0; sdi = 1'b0; idle(6);
  endtask

  task automatic read_status(output logic [15:0] r);
    daisy = 1'b0;
    frame(16, 64'h0300, 1'b0, 1'b0, r);
  endtask

  function automatic logic [15:0] resp(input logic e);
    return {e, e, 3'b000, 1'b1, 3'b000, 7'b0};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail);
    $finish;
  end

  initial begin
    idle(5); rst_n = 1'b1; idle(3);
    check("R9 status after reset", {8'h0, status}, 16'h0000);
    check("R10 gef after reset", {15'h0, gef}, 16'h0001);

    frame(0, 64'h0, 1'b0, 1'b0, rx);
    check("R12 zero-pulse frame", {8'h0, status}, 16'h0000);

    read_status(rx);
    check("R11 first response", rx, {1'b1, 8'h00, 7'b0});
    check("R9 power-on bit set by read", {8'h0, status}, 16'h0008);
    check("R10 gef clear", {15'h0, gef}, 16'h0000);
    read_status(rx);
    check("R11 clean response", rx, resp(1'b0));

    for (int k = 0; k < 15; k++) begin
      daisy = VEC[k][72];
      frame(int'(VEC[k][71:65]), VEC[k][64:1], 1'b0, 1'b0, rx);
      check($sformatf("R7 vector %0d same-frame response", k), {15'h0, rx[14]}, 16'h0);
      check($sformatf("R1 R2 R3 R4 R5 vector %0d error bit", k), {15'h0, status[7]}, {15'h0, VEC[k][0]});
      read_status(rx);
      check($sformatf("R7 vector %0d next response", k), rx, resp(VEC[k][0]));
    end

    // R6 SCLK high at CSN fall
    frame(16, 64'h17AA, 1'b1, 1'b0, rx);
    check("R6 high at fall", {15'h0, status[7]}, 16'h1);
    read_status(rx);
    // R6 SCLK high at CSN rise (16th pulse supplied by the high level)
    frame(15, 64'h0BD5, 1'b0, 1'b1, rx);
    check("R6 high at rise", {15'h0, status[7]}, 16'h1);
    read_status(rx);
    check("R6 response shows error", rx, resp(1'b1));

    // R8 sticky across a correct non-status frame
    frame(8, 64'h17, 1'b0, 1'b0, rx);
    frame(16, 64'h17AA, 1'b0, 1'b0, rx);
    check("R8 sticky", {8'h0, status}, 16'h0088);
    read_status(rx);
    check("R8 cleared by read", {8'h0, status}, 16'h0008);

    // R8 erroneous read does not clear
    frame(8, 64'h17, 1'b0, 1'b0, rx);
    frame(8, 64'h03, 1'b0, 1'b0, rx);
    check("R8 bad read keeps error", {8'h0, status}, 16'h0088);
    // R12 zero-pulse frame leaves the error set
    frame(0, 64'h0, 1'b0, 1'b0, rx);
    check("R12 zero-pulse keeps error", {8'h0, status}, 16'h0088);
    read_status(rx);
    check("R8 good read clears", {8'h0, status}, 16'h0008);

    // R10 fault merging
    fault = 5'b00001;
    read_status(rx);
    check("R10 fault bit 0 response", rx, {1'b1, 8'h0A, 7'b0});
    fault = 5'b10000;
    idle(2);
    check("R10 fault bit 4 status", {8'h0, status}, 16'h0048);
    check("R10 fault gef", {15'h0, gef}, 16'h0001);
    fault = '0;
    idle(2);
    check("R10 gef after faults gone", {15'h0, gef}, 16'h0000);

    // R9 reset restores the power-on indication
    rst_n = 1'b0; idle(3); rst_n = 1'b1; idle(3);
    check("R9 status after second reset", {8'h0, status}, 16'h0000);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule